// File: doc/BRIEF.md
# Four-Way Pairwise LRU Replacement Controller

This block keeps the replacement state of a four-way set-associative cache. Every set owns a six-bit ordering word that holds one bit for each pair of ways. The bit records which way of its pair was used more recently. When the cache reports a hit or a fill on a set, the word for that set is rewritten so that the way just used becomes the most recent. The other pairs are left alone.

A separate lookup index selects the set whose least recently used way is driven combinationally on the victim output. The miss-handling logic uses that way as the replacement target.

A global purge clears every ordering word in one clock cycle. In that same cycle the block raises a pulse that tells the tag array to clear all of its valid bits. Reset also clears every word, so a purge can be issued at once after reset.

Top module: `lru4_pair_ctrl`

## Requirements
- R1: After reset, every set reports way 3 as its victim, because all ordering words read as zero.
- R2: An access to a set makes the accessed way the most recent one. Over any sequence of accesses, the victim of a set equals the way touched longest ago, or the way with the highest number if that way has never been touched since the last clear.
- R3: Within a word, the bit for pair (i, j), where i < j, sits at bit position 5 minus the lexicographic index of the pair. This gives (0,1)=5, (0,2)=4, (0,3)=3, (1,2)=2, (1,3)=1 and (2,3)=0. An access to way w clears the bits of the pairs in which w is the lower way, and sets the bits of the pairs in which w is the higher way. It leaves the other three bits unchanged.
- R4: Way w is the victim when every pair containing w says that the other way is more recent. That means a bit value of 1 where w is the lower way and 0 where w is the higher way.
- R5: An access changes only the word of the set it names. The victim of every other set, including the top set index, is unaffected.
- R6: A purge clears the word of every set within one cycle. From the next cycle on, every set reports way 3.
- R7: The valid-clear output `inv_all_o` is high in exactly the cycles in which `purge_req` is high.
- R8: When a purge and an access arrive in the same cycle, the purge takes effect and the access update is discarded.
- R9: While `acc_valid` is low, the values on `acc_set` and `acc_way` change no state.
- R10: `victim_way` follows `look_set` combinationally and reflects an access from the first cycle after the clock edge that registered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every ordering word |
| acc_valid | input | 1 | Hit or fill strobe for the set and way below |
| acc_set | input | 6 | Set index of the access |
| acc_way | input | 2 | Way that was hit or filled |
| look_set | input | 6 | Set index whose victim is reported |
| purge_req | input | 1 | Global purge of all replacement state |
| victim_way | output | 2 | Least recently used way of `look_set` |
| inv_all_o | output | 1 | Tells the tag array to clear all valid bits this cycle |

## Verification
The hardest state to reach from the ports is a set whose order has been fully permuted, so that each of the four ways has been the victim at some point. A further hard case is a purge that lands in the same cycle as an access whose update would have changed the victim. A fixed vector table walks one set through every victim position. A long random run then compares each set against a recency-list model and drops in purges from time to time. A directed collision test pairs a purge with an access to way 3. If that access were not dropped, way 3 would no longer be the victim.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int ORD_W = WAYS * (WAYS - 1) / 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [ORD_W-1:0] ord_t;

    // Way chosen when no way satisfies the victim decode
    localparam way_t FALLBACK_WAY = way_t'(0);

    // Bit position of pair (lo, hi), lo < hi: highest bit for the first pair
    function automatic int pair_pos(input int lo, input int hi);
        int idx;
        idx = lo * WAYS - (lo * (lo + 1)) / 2 + (hi - lo - 1);
        return ORD_W - 1 - idx;
    endfunction
endpackage

// File: rtl/lru4_update.sv
module lru4_update
    import lru4_pkg::*;
(
    input  ord_t old_word,
    input  way_t way,
    output ord_t new_word
);
    // Build the set and clear masks for the accessed way
    ord_t set_mask;
    ord_t clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int lo = 0; lo < WAYS; lo++) begin
            for (int hi = lo + 1; hi < WAYS; hi++) begin
                if (int'(way) == lo) begin
                    clr_mask[pair_pos(lo, hi)] = 1'b1;
                end else if (int'(way) == hi) begin
                    set_mask[pair_pos(lo, hi)] = 1'b1;
                end
            end
        end
        new_word = (old_word & ~clr_mask) | set_mask;
    end

    // R3: exactly WAYS-1 bits are touched by any access
    always_comb begin
        if (!$isunknown(way)) begin
            assert ($countones(set_mask | clr_mask) == WAYS - 1)
                else $error("p_touch_count_r3");
        end
    end
endmodule

// File: rtl/lru4_victim.sv
module lru4_victim
    import lru4_pkg::*;
(
    input  ord_t word,
    output way_t victim
);
    logic [WAYS-1:0] match;

    // A way is the victim if every partner is recorded as more recent
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = 1'b1;
            for (int o = 0; o < WAYS; o++) begin
                if (o < w) begin
                    if (word[pair_pos(o, w)] != 1'b0) match[w] = 1'b0;
                end else if (o > w) begin
                    if (word[pair_pos(w, o)] != 1'b1) match[w] = 1'b0;
                end
            end
        end
    end

    // Lowest matching way; fallback covers inconsistent orderings
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = FALLBACK_WAY;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && !found) begin
                victim = way_t'(w);
                found  = 1'b1;
            end
        end
    end

    // R4: decode rows are mutually exclusive
    always_comb begin
        if (!$isunknown(word)) begin
            assert ($onehot0(match)) else $error("p_rows_exclusive_r4");
        end
    end
endmodule

// File: rtl/lru4_store.sv
module lru4_store
    import lru4_pkg::*;
#(
    parameter int NSETS = 64,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  ord_t          wr_data,
    input  logic [SW-1:0] rd_a_set,
    output ord_t          rd_a_word,
    input  logic [SW-1:0] rd_b_set,
    output ord_t          rd_b_word
);
    typedef struct packed {
        logic [NSETS-1:0][ORD_W-1:0] words;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.words = '0;
        end else if (wr_en) begin
            st_d.words[wr_set] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_word = st_q.words[rd_a_set];
    assign rd_b_word = st_q.words[rd_b_set];

    // R6: a clear leaves every word at zero
    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.words == '0));

    // R2: a write without clear lands in the addressed set
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (st_q.words[$past(wr_set)] == $past(wr_data)));

    // R8: a clear wins over a concurrent write
    p_clear_beats_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wr_en) |=> (st_q.words[$past(wr_set)] == '0));
endmodule

// File: rtl/lru4_pair_ctrl.sv
module lru4_pair_ctrl
    import lru4_pkg::*;
#(
    parameter int NSETS = 64,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [SW-1:0] acc_set,
    input  logic [1:0]    acc_way,
    input  logic [SW-1:0] look_set,
    input  logic          purge_req,
    output logic [1:0]    victim_way,
    output logic          inv_all_o
);
    ord_t acc_word_q;
    ord_t acc_word_d;
    ord_t look_word_q;
    way_t victim_d;

    lru4_store #(.NSETS(NSETS)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (purge_req),
        .wr_en     (acc_valid),
        .wr_set    (acc_set),
        .wr_data   (acc_word_d),
        .rd_a_set  (look_set),
        .rd_a_word (look_word_q),
        .rd_b_set  (acc_set),
        .rd_b_word (acc_word_q)
    );

    lru4_update i_update (
        .old_word (acc_word_q),
        .way      (way_t'(acc_way)),
        .new_word (acc_word_d)
    );

    lru4_victim i_victim (
        .word   (look_word_q),
        .victim (victim_d)
    );

    assign victim_way = victim_d;
    assign inv_all_o  = purge_req;

    // R2: the way just accessed is not the victim of its set next cycle
    p_not_victim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !purge_req && acc_set == look_set) |=>
        ((look_set != $past(look_set)) || (victim_way != $past(acc_way))));

    // R6: after a purge every set reports the top way
    p_purge_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        purge_req |=> (victim_way == 2'd3));

    // R9: no strobe and no purge keeps the looked-up victim
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !purge_req) |=>
        ((look_set != $past(look_set)) || $stable(victim_way)));
endmodule

// File: tb/test_lru4_pair_ctrl.sv
`timescale 1ns/100ps
module test_lru4_pair_ctrl;
    localparam int NS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_set = '0;
    logic [1:0] acc_way = '0;
    logic [5:0] look_set = '0;
    logic       purge_req = 1'b0;
    logic [1:0] victim_way;
    logic       inv_all_o;

    int total = 0;
    int bad = 0;
    int mdl [NS][4];

    // {way, expected victim} for consecutive accesses to one set (R2, R3, R4)
    localparam logic [3:0] VEC [10] = '{4'hE, 4'h9, 4'h1, 4'h7, 4'hE,
                                        4'h8, 4'h8, 4'h1, 4'h7, 4'hE};

    always #2.5 clk = ~clk;

    lru4_pair_ctrl #(.NSETS(NS)) i_lru4_pair_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_set    (acc_set),
        .acc_way    (acc_way),
        .look_set   (look_set),
        .purge_req  (purge_req),
        .victim_way (victim_way),
        .inv_all_o  (inv_all_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < 4; k++) mdl[s][k] = k;
    endtask

    task automatic model_touch(input int s, input int w);
        int p;
        p = 0;
        for (int k = 0; k < 4; k++) if (mdl[s][k] == w) p = k;
        for (int k = p; k > 0; k--) mdl[s][k] = mdl[s][k-1];
        mdl[s][0] = w;
    endtask

    task automatic look(input int s, input int exp, input string req);
        look_set = 6'(s);
        #1;
        check(req, int'(victim_way), exp);
    endtask

    // One cycle of stimulus; returns at the following falling edge
    task automatic step(input logic v, input int s, input int w, input logic p);
        @(negedge clk);
        acc_valid = v;
        acc_set   = 6'(s);
        acc_way   = 2'(w);
        purge_req = p;
        look_set  = 6'(s);
        #1;
        check("R7 inv_all", int'(inv_all_o), int'(p));
        @(negedge clk);
        acc_valid = 1'b0;
        purge_req = 1'b0;
        #1;
        check("R7 inv_all low", int'(inv_all_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every set
        for (int s = 0; s < NS; s++) look(s, 3, "R1 reset victim");

        // R2 R3 R4 R10: vector table on set 5
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 5, int'(VEC[i][3:2]), 1'b0);
            check("R10 victim after access", int'(victim_way), int'(VEC[i][1:0]));
        end

        // R5: neighbours untouched, top index usable
        look(4, 3, "R5 set 4 untouched");
        look(6, 3, "R5 set 6 untouched");
        step(1'b1, NS - 1, 3, 1'b0);
        check("R5 top set", int'(victim_way), 2);
        look(5, 2, "R5 set 5 kept");

        // R9: strobe low with way 2 on set 5 (victim 2) changes nothing
        step(1'b0, 5, 2, 1'b0);
        check("R9 ignored without strobe", int'(victim_way), 2);

        // R6: purge clears all sets
        step(1'b0, 0, 0, 1'b1);
        look(5, 3, "R6 set 5 cleared");
        look(NS - 1, 3, "R6 top set cleared");
        look(9, 3, "R6 set 9 cleared");

        // R8: purge with access to way 3 on set 7, access dropped
        step(1'b1, 7, 0, 1'b0);
        check("R8 setup", int'(victim_way), 3);
        step(1'b1, 7, 3, 1'b1);
        check("R8 purge wins", int'(victim_way), 3);
        look(7, 3, "R8 set 7 zero");

        // R2: random sequences against a recency-list model
        model_clear();
        for (int n = 0; n < 4000; n++) begin
            int s;
            int w;
            logic p;
            s = int'($urandom_range(0, NS - 1));
            w = int'($urandom_range(0, 3));
            p = ($urandom_range(0, 199) == 0);
            step(1'b1, s, w, p);
            if (p) model_clear();
            else model_touch(s, w);
            check("R2 random victim", int'(victim_way), mdl[s][3]);
            if (n % 16 == 0) begin
                int o;
                o = int'($urandom_range(0, NS - 1));
                look(o, mdl[o][3], "R5 random other set");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule